// File: doc/BRIEF.md
# BCH8 Error Location Bit Corrector

This block applies the result of a BCH decode of one 512-byte sector to that sector's data, which sits in a byte-wide buffer. A single `start` pulse hands it three 32-bit location words and a status word. The status word carries the error count and the top byte of the packed location field. The block unpacks up to eight 13-bit bit positions and restores their encoding. It drops any position that lies outside the sector. For each remaining position it flips the addressed bit with a read-modify-write on the buffer port.

When all reported positions have been handled, it pulses `done` with the number of bits it actually flipped. When the count is above eight, it leaves the buffer untouched and raises an overflow flag with `done`. A later stage can then run the erased-page test or declare the sector failed. While the block is working, `busy` stays high and further starts are ignored.

Top module: `bitfix_top`

## Requirements
- R1: While reset is held and while idle, `busy` and `done` are low and neither buffer strobe is asserted.
- R2: The error count is `statusWord[13:10]`. Every other status bit except `[23:16]` has no effect. A count of 0 produces `done` with `fixCount` = 0 and no buffer access.
- R3: A count of 9 to 15 produces `done` with `tooMany` = 1 and `fixCount` = 0, and no buffer access. `tooMany` is never high without `done`.
- R4: The 104-bit field {statusWord[23:16], errWord2, errWord1, errWord0} holds position i in bits [13i+12:13i], for i = 0 to 7.
- R5: The true bit position is the unpacked 13-bit value with its bits 0 and 1 inverted.
- R6: Position p selects byte p[11:3] and bit p[2:0] of that byte. The flip is a read strobe followed, in the next cycle, by a write to the same address. The write data is the read data with exactly that one bit inverted. The read data arrives one cycle after the read strobe.
- R7: A position of 4096 or more causes no buffer access and is not counted.
- R8: `fixCount` with `done` equals the number of bits flipped. `done` is a one-cycle pulse.
- R9: `busy` rises the cycle after an accepted start and falls the cycle after `done`. A start while busy is ignored.
- R10: Only positions 0 to count-1 are used, in index order. Repeating a position flips its bit twice, which restores the original value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a correction; sampled only when idle |
| errWord0 | input | 32 | Location bits 31:0 of the packed field |
| errWord1 | input | 32 | Location bits 63:32 of the packed field |
| errWord2 | input | 32 | Location bits 95:64 of the packed field |
| statusWord | input | 32 | Error count in [13:10], location bits 103:96 in [23:16] |
| busy | output | 1 | Correction in progress |
| done | output | 1 | One-cycle completion pulse |
| tooMany | output | 1 | With done: count above eight, nothing corrected |
| fixCount | output | 4 | With done: number of bits flipped |
| bufAddr | output | 9 | Sector buffer byte address |
| bufRdEn | output | 1 | Buffer read strobe |
| bufRdData | input | 8 | Buffer read data, one cycle after the strobe |
| bufWrEn | output | 1 | Buffer write strobe |
| bufWrData | output | 8 | Buffer write data |

## Verification
The assertions check the following on every cycle:
- each write follows a read of the same address, and flips exactly one bit of the returned byte;
- the strobes stay quiet while idle;
- `busy` holds until the one-cycle `done`;
- the overflow flag only appears with `done` and a zero count.

Only the bench scenarios can show that the correct bits are flipped. That covers the unpacking of positions that straddle word boundaries, the low-bit inversion, skipping positions at 4096 and above, ignoring positions past the count, undoing a repeated position, and ignoring a start issued mid-run. The bench does this by comparing every write and the final buffer image against values computed from the requirements.

// File: rtl/bitfix_pkg.sv
package bitfix_pkg;

  // Strobes from the sequencer to the datapath and buffer port
  typedef struct packed {
    logic capture;  // latch words, count; clear index and tally
    logic advance;  // move to next position index
    logic bump;     // one more bit flipped
    logic rdEn;     // buffer read of current byte
    logic wrEn;     // buffer write of modified byte
  } fixStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EVAL,
    S_STEP,
    S_FLIP,
    S_FIN
  } fixState_t;

endpackage

// File: rtl/bitfix_datapath.sv
module bitfix_datapath
  import bitfix_pkg::*;
#(
  parameter int POS_W        = 13,
  parameter int MAX_FIX      = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = 4,
  parameter int WORD_W       = 32,
  localparam int FIELD_W     = POS_W * MAX_FIX,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int IDX_W       = $clog2(MAX_FIX),
  localparam int SECTOR_BITS = SECTOR_BYTES * 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fixStrobe_t         strobe,
  input  logic [FIELD_W-1:0] fieldIn,
  input  logic [CNT_W-1:0]   countIn,
  input  logic [7:0]         rdData,
  output logic               zeroCount,
  output logic               overCount,
  output logic               curInRange,
  output logic               lastIdx,
  output logic [ADDR_W-1:0]  addr,
  output logic [7:0]         wrData,
  output logic [CNT_W-1:0]   fixCount
);

  logic [FIELD_W-1:0] fieldQ;
  logic [CNT_W-1:0]   countQ;
  logic [IDX_W-1:0]   idxQ;
  logic [CNT_W-1:0]   fixQ;
  logic [POS_W-1:0]   posArr [MAX_FIX];
  logic [POS_W-1:0]   curPos;
  logic [2:0]         bitSel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fieldQ <= '0;
      countQ <= '0;
      idxQ   <= '0;
      fixQ   <= '0;
    end else if (strobe.capture) begin
      fieldQ <= fieldIn;
      countQ <= countIn;
      idxQ   <= '0;
      fixQ   <= '0;
    end else begin
      if (strobe.advance) idxQ <= idxQ + IDX_W'(1);
      if (strobe.bump)    fixQ <= fixQ + CNT_W'(1);
    end
  end

  // Slice each position out of the packed field and undo the two-bit inversion
  for (genvar i = 0; i < MAX_FIX; i++) begin : g_unpack
    assign posArr[i] = fieldQ[i*POS_W +: POS_W] ^ POS_W'(3);
  end

  assign curPos     = posArr[idxQ];
  assign curInRange = {1'b0, curPos} < (POS_W+1)'(SECTOR_BITS);
  assign addr       = curPos[3 +: ADDR_W];
  assign bitSel     = curPos[2:0];
  assign wrData     = rdData ^ (8'b1 << bitSel);

  assign zeroCount  = (countQ == '0);
  assign overCount  = (countQ > CNT_W'(MAX_FIX));
  assign lastIdx    = ((CNT_W'(idxQ) + CNT_W'(1)) == countQ);
  assign fixCount   = fixQ;

endmodule

// File: rtl/bitfix_control.sv
module bitfix_control
  import bitfix_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       zeroCount,
  input  logic       overCount,
  input  logic       curInRange,
  input  logic       lastIdx,
  output fixStrobe_t strobe,
  output logic       busy,
  output logic       done
);

  fixState_t stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= S_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          strobe.capture = 1'b1;
          stateD         = S_EVAL;
        end
      end
      S_EVAL: begin
        if (zeroCount || overCount) stateD = S_FIN;
        else                        stateD = S_STEP;
      end
      S_STEP: begin
        if (curInRange) begin
          strobe.rdEn = 1'b1;
          stateD      = S_FLIP;
        end else begin
          strobe.advance = 1'b1;
          stateD         = lastIdx ? S_FIN : S_STEP;
        end
      end
      S_FLIP: begin
        strobe.wrEn    = 1'b1;
        strobe.bump    = 1'b1;
        strobe.advance = 1'b1;
        stateD         = lastIdx ? S_FIN : S_STEP;
      end
      S_FIN:   stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  assign busy = (stateQ != S_IDLE);
  assign done = (stateQ == S_FIN);

endmodule

// File: rtl/bitfix_top.sv
module bitfix_top
  import bitfix_pkg::*;
#(
  parameter int POS_W        = 13,
  parameter int MAX_FIX      = 8,
  parameter int SECTOR_BYTES = 512,
  parameter int CNT_W        = 4,
  parameter int CNT_LSB      = 10,
  parameter int TOP_LSB      = 16,
  localparam int ADDR_W      = $clog2(SECTOR_BYTES),
  localparam int FIELD_W     = POS_W * MAX_FIX,
  localparam int TOP_W       = FIELD_W - 96
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       errWord0,
  input  logic [31:0]       errWord1,
  input  logic [31:0]       errWord2,
  input  logic [31:0]       statusWord,
  output logic              busy,
  output logic              done,
  output logic              tooMany,
  output logic [CNT_W-1:0]  fixCount,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufRdEn,
  input  logic [7:0]        bufRdData,
  output logic              bufWrEn,
  output logic [7:0]        bufWrData
);

  fixStrobe_t         strobe;
  logic               zeroCount, overCount, curInRange, lastIdx;
  logic [FIELD_W-1:0] fieldIn;
  logic [CNT_W-1:0]   countIn;
  logic               unusedStatus;

  assign fieldIn = {statusWord[TOP_LSB +: TOP_W], errWord2, errWord1, errWord0};
  assign countIn = statusWord[CNT_LSB +: CNT_W];
  assign unusedStatus = ^{statusWord[31:TOP_LSB+TOP_W], statusWord[TOP_LSB-1:CNT_LSB+CNT_W],
                          statusWord[CNT_LSB-1:0]};

  bitfix_control i_control (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .zeroCount  (zeroCount),
    .overCount  (overCount),
    .curInRange (curInRange),
    .lastIdx    (lastIdx),
    .strobe     (strobe),
    .busy       (busy),
    .done       (done)
  );

  bitfix_datapath #(
    .POS_W        (POS_W),
    .MAX_FIX      (MAX_FIX),
    .SECTOR_BYTES (SECTOR_BYTES),
    .CNT_W        (CNT_W)
  ) i_datapath (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .fieldIn    (fieldIn),
    .countIn    (countIn),
    .rdData     (bufRdData),
    .zeroCount  (zeroCount),
    .overCount  (overCount),
    .curInRange (curInRange),
    .lastIdx    (lastIdx),
    .addr       (bufAddr),
    .wrData     (bufWrData),
    .fixCount   (fixCount)
  );

  assign bufRdEn = strobe.rdEn;
  assign bufWrEn = strobe.wrEn;
  assign tooMany = done && overCount;

endmodule

// File: rtl/bitfix_checker.sv
module bitfix_checker #(
  parameter int MAX_FIX = 8,
  parameter int CNT_W   = 4,
  parameter int ADDR_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              tooMany,
  input logic [CNT_W-1:0]  fixCount,
  input logic [ADDR_W-1:0] bufAddr,
  input logic              bufRdEn,
  input logic [7:0]        bufRdData,
  input logic              bufWrEn,
  input logic [7:0]        bufWrData
);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bufRdEn && !bufWrEn));

  a_r3_overflow_only_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    tooMany |-> (done && fixCount == '0));

  a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrEn |-> $past(bufRdEn));

  a_r6_same_address: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrEn |-> (bufAddr == $past(bufAddr)));

  a_r6_single_bit_flip: assert property (@(posedge clk) disable iff (!rst_n)
    bufWrEn |-> ($countones(bufWrData ^ bufRdData) == 1));

  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bufRdEn, bufWrEn}));

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fixCount <= CNT_W'(MAX_FIX)));

  a_r9_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  a_r9_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

bind bitfix_top bitfix_checker #(
  .MAX_FIX (MAX_FIX),
  .CNT_W   (CNT_W),
  .ADDR_W  (ADDR_W)
) i_bitfix_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .tooMany   (tooMany),
  .fixCount  (fixCount),
  .bufAddr   (bufAddr),
  .bufRdEn   (bufRdEn),
  .bufRdData (bufRdData),
  .bufWrEn   (bufWrEn),
  .bufWrData (bufWrData)
);

// File: tb/test_bitfix_top.sv
`timescale 1ns/1ps
module test_bitfix_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] w0 = '0, w1 = '0, w2 = '0, st = '0;
  logic        busy, done, tooMany, bufRdEn, bufWrEn;
  logic [3:0]  fixCount;
  logic [8:0]  bufAddr;
  logic [7:0]  bufRdData = '0, bufWrData;

  always #2 clk = ~clk;  // 250 MHz

  bitfix_top i_bitfix_top (
    .clk (clk), .rst_n (rst_n), .start (start),
    .errWord0 (w0), .errWord1 (w1), .errWord2 (w2), .statusWord (st),
    .busy (busy), .done (done), .tooMany (tooMany), .fixCount (fixCount),
    .bufAddr (bufAddr), .bufRdEn (bufRdEn), .bufRdData (bufRdData),
    .bufWrEn (bufWrEn), .bufWrData (bufWrData)
  );

  // Sector buffer model: read data one cycle after the strobe
  logic [7:0] mem    [512];
  logic [7:0] refMem [512];
  always @(posedge clk) begin
    if (bufRdEn) bufRdData <= mem[bufAddr];
    if (bufWrEn) mem[bufAddr] <= bufWrData;
  end

  typedef struct { int addr; int data; } wrItem_t;
  wrItem_t wrQ[$];
  int      resQ[$];
  int      errors = 0, checks = 0, doneSeen = 0;
  wrItem_t it;
  int      res;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected writes and results as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (bufWrEn) begin
        if (wrQ.size() == 0) check(1'b0, "R10 unexpected write", int'(bufAddr), -1);
        else begin
          it = wrQ.pop_front();
          check(int'(bufAddr) == it.addr, "R6 write address", int'(bufAddr), it.addr);
          check(int'(bufWrData) == it.data, "R5 write data", int'(bufWrData), it.data);
        end
      end
      if (done) begin
        res = (resQ.size() == 0) ? -1 : resQ.pop_front();
        check(int'(fixCount) == (res % 16), "R8 corrected count", int'(fixCount), res % 16);
        check(int'(tooMany) == (res / 16), "R3 overflow flag", int'(tooMany), res / 16);
        check(wrQ.size() == 0, "R7 missing writes at done", wrQ.size(), 0);
        doneSeen++;
      end
    end
  end

  task automatic runCase(input int cnt, input int pos[8], input bit poke);
    logic [103:0] f;
    int nFix, a, d;
    for (int i = 0; i < 8; i++) f[i*13 +: 13] = 13'(pos[i]) ^ 13'd3;
    nFix = 0;
    if (cnt >= 1 && cnt <= 8)
      for (int i = 0; i < cnt; i++)
        if (pos[i] < 4096) begin
          a = pos[i] >> 3;
          refMem[a] = refMem[a] ^ 8'(1 << (pos[i] & 7));
          wrQ.push_back('{a, int'(refMem[a])});
          nFix++;
        end
    resQ.push_back((cnt > 8) ? 16 : nFix);
    d = doneSeen;
    @(negedge clk);
    w0 = f[31:0]; w1 = f[63:32]; w2 = f[95:64];
    st = {8'hA5, f[103:96], 2'b11, 4'(cnt), 10'h3FF};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R9 busy after start", int'(busy), 1);
    if (poke) begin
      @(negedge clk);
      w0 = ~w0; w2 = ~w2; st = st ^ 32'h0000_2C00;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int n = 0; n < 200 && doneSeen == d; n++) @(negedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R9 idle after done", int'(busy), 0);
  endtask

  initial begin
    int bad;
    for (int i = 0; i < 512; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    check(!busy && !done && !bufRdEn && !bufWrEn, "R1 reset state",
          int'({busy, done, bufRdEn, bufWrEn}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !bufRdEn && !bufWrEn, "R1 idle after reset",
          int'({busy, bufRdEn, bufWrEn}), 0);

    runCase(0, '{5, 9, 13, 21, 40, 41, 42, 43}, 1'b0);          // R2 zero count
    runCase(1, '{5, 0, 0, 0, 0, 0, 0, 0}, 1'b0);                 // R4 R5 single
    runCase(8, '{0, 4095, 1234, 8, 4094, 17, 2047, 777}, 1'b1);  // R4 straddling, R9 poke
    runCase(3, '{100, 5000, 8191, 1, 2, 3, 4, 5}, 1'b0);         // R7 out of range
    runCase(3, '{4096, 101, 4095, 0, 0, 0, 0, 0}, 1'b0);         // R7 boundary
    runCase(9, '{10, 11, 12, 13, 14, 15, 16, 17}, 1'b0);         // R3
    runCase(15, '{10, 11, 12, 13, 14, 15, 16, 17}, 1'b0);        // R3
    runCase(2, '{321, 321, 0, 0, 0, 0, 0, 0}, 1'b0);             // R10 repeat
    runCase(2, '{10, 20, 30, 40, 50, 60, 70, 80}, 1'b0);         // R10 past count
    runCase(4, '{1, 2, 3, 6, 0, 0, 0, 0}, 1'b0);                 // R5 low bits

    check(resQ.size() == 0, "R8 results outstanding", resQ.size(), 0);
    bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== refMem[i]) bad++;
    check(bad == 0, "R6 final buffer image mismatches", bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R9 run did not finish actual=%0d expected=%0d", doneSeen, 10);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule